// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block models the digital input side of a serial-loaded 16-bit DAC. A fast system clock samples three slow serial lines: an active-low frame select, a serial clock and a data line. A frame starts when the select line falls. After that, the block takes one data bit on every falling edge of the serial clock. Once 24 bits have arrived, it writes a 16-bit DAC code register and an 8-bit mode register in a single step.

The code register holds a two's-complement value, where zero means mid-scale. The block also provides an unsigned offset-binary copy of that code for a downstream tap decoder. A one-cycle strobe marks every register write. If the select line rises before the frame is complete, the block drops the partial frame. Once a frame has executed, the block ignores further serial clocks until the select line has risen and fallen again.

Top module: `sdac_frame_rx`

## Requirements
- R1: After reset, `code_o` is 0, `mode_o` is 0, `offset_o` is 16'h8000 and `update_o` is low.
- R2: A falling edge on `sync_n_i` arms the receiver with an empty bit count, even when an earlier frame was cut short.
- R3: While `sync_n_i` is low, each falling edge of `sclk_i` shifts `din_i` in, most significant bit first. Of the 24 bits received, the first 8 become `mode_o` and the last 16 become `code_o`.
- R4: The frame executes on the 24th falling edge of `sclk_i` while `sync_n_i` is still low. It does not wait for `sync_n_i` to rise.
- R5: After a frame has executed, further `sclk_i` falling edges have no effect until `sync_n_i` has gone high and then low again.
- R6: If `sync_n_i` rises before the 24th edge, the block discards the partial frame. `code_o` and `mode_o` keep their values and no strobe is issued.
- R7: `offset_o` equals `code_o` with its most significant bit inverted, so code 16'h8000 gives 0 and code 16'h7FFF gives 16'hFFFF.
- R8: `update_o` is high for exactly one clock cycle for each executed frame, in the same cycle that the new `code_o`, `mode_o` and `offset_o` first appear.
- R9: A falling edge of `sclk_i` that the block detects in the same cycle as the falling edge of `sync_n_i` counts as the first bit of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n_i | input | 1 | Active-low frame select, asynchronous to clk |
| sclk_i | input | 1 | Serial bit clock; the block samples data on its falling edge |
| din_i | input | 1 | Serial data, most significant bit first |
| code_o | output | 16 | Stored DAC code, two's complement |
| mode_o | output | 8 | Stored mode byte |
| offset_o | output | 16 | Offset-binary form of the stored code |
| update_o | output | 1 | One-cycle strobe on every register write |

## Verification
Arming on the select falling edge and capturing a bit on a serial-clock falling edge can fall in the same system-clock cycle. The bench provokes this by lowering `sync_n_i` and `sclk_i` at the same instant, with the first data bit already on the line. It then sends only 23 further edges. The bench judges the result by whether that frame executes with the expected code and mode. If the coincident edge were dropped, the frame would stay one bit short, never produce a strobe, and leave an expected item in the scoreboard.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned DEF_CODE_W = 16;
  localparam int unsigned DEF_MODE_W = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  // index of each line inside the synchroniser bus
  localparam int unsigned IDX_SEL  = 0;
  localparam int unsigned IDX_SCLK = 1;
  localparam int unsigned IDX_DATA = 2;
  localparam int unsigned N_LINES  = 3;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_s_i,
  input  logic               sclk_s_i,
  input  logic               data_s_i,
  output logic               done_o,
  output logic [FRAME_W-1:0] word_o
);
  localparam int unsigned CW = $clog2(FRAME_W);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  logic          sel_q, sclk_q, armed;
  logic [CW-1:0] cnt;
  logic [FRAME_W-1:0] sh;
  logic          sel_fall, sclk_fall;

  assign sel_fall  = sel_q & ~sel_s_i;
  assign sclk_fall = sclk_q & ~sclk_s_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b1;
      sclk_q <= 1'b1;
      armed  <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      done_o <= 1'b0;
      word_o <= '0;
    end else begin
      sel_q  <= sel_s_i;
      sclk_q <= sclk_s_i;
      done_o <= 1'b0;
      if (sel_s_i) begin
        armed <= 1'b0;
      end else if (sel_fall) begin
        armed <= 1'b1;
        cnt   <= sclk_fall ? CW'(1) : '0;
        if (sclk_fall) sh <= {sh[FRAME_W-2:0], data_s_i};
      end else if (armed && sclk_fall) begin
        sh <= {sh[FRAME_W-2:0], data_s_i};
        if (cnt == LAST) begin
          armed  <= 1'b0;
          cnt    <= '0;
          done_o <= 1'b1;
          word_o <= {sh[FRAME_W-2:0], data_s_i};
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(FRAME_W));
  p_arm_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    sel_fall |=> armed);
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_disarm_after_frame_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !armed);
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs #(
  parameter int unsigned CODE_W = 16,
  parameter int unsigned MODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_i,
  input  logic [CODE_W+MODE_W-1:0] word_i,
  output logic [CODE_W-1:0]        code_o,
  output logic [MODE_W-1:0]        mode_o,
  output logic [CODE_W-1:0]        offset_o,
  output logic                     upd_o
);
  localparam int unsigned MSB = CODE_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o   <= '0;
      mode_o   <= '0;
      offset_o <= {1'b1, {(CODE_W-1){1'b0}}};
      upd_o    <= 1'b0;
    end else begin
      upd_o <= load_i;
      if (load_i) begin
        code_o   <= word_i[CODE_W-1:0];
        mode_o   <= word_i[CODE_W+MODE_W-1:CODE_W];
        offset_o <= {~word_i[MSB], word_i[MSB-1:0]};
      end
    end
  end

  p_hold_without_load_r6: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(code_o) && $stable(mode_o) && !upd_o));
  p_offset_map_r7: assert property (@(posedge clk) disable iff (rst)
    offset_o == {~code_o[MSB], code_o[MSB-1:0]});
  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    upd_o |=> !upd_o);
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx #(
  parameter int unsigned CODE_W = sdac_pkg::DEF_CODE_W,
  parameter int unsigned MODE_W = sdac_pkg::DEF_MODE_W,
  parameter int unsigned SYNC_STAGES = sdac_pkg::DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic [CODE_W-1:0] code_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [CODE_W-1:0] offset_o,
  output logic              update_o
);
  import sdac_pkg::*;
  localparam int unsigned FRAME_W = CODE_W + MODE_W;
  localparam logic [N_LINES-1:0] IDLE = N_LINES'(3'b011);

  logic [N_LINES-1:0] raw, synced;
  logic               done;
  logic [FRAME_W-1:0] word;

  assign raw[IDX_SEL]  = sync_n_i;
  assign raw[IDX_SCLK] = sclk_i;
  assign raw[IDX_DATA] = din_i;

  sdac_sync #(.W(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(synced)
  );

  sdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst),
    .sel_s_i(synced[IDX_SEL]), .sclk_s_i(synced[IDX_SCLK]),
    .data_s_i(synced[IDX_DATA]),
    .done_o(done), .word_o(word)
  );

  sdac_regs #(.CODE_W(CODE_W), .MODE_W(MODE_W)) u_regs (
    .clk(clk), .rst(rst), .load_i(done), .word_i(word),
    .code_o(code_o), .mode_o(mode_o), .offset_o(offset_o), .upd_o(update_o)
  );
endmodule

// File: tb/test_sdac_frame_rx.sv
module test_sdac_frame_rx;
  logic clk = 1'b0, rst = 1'b1;
  logic sync_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic [15:0] code, offset;
  logic [7:0]  mode;
  logic        upd;
  int checks = 0, failures = 0;
  bit  finished = 1'b0;
  logic [23:0] exp_q[$];
  logic        upd_prev = 1'b0;

  always #5 clk = ~clk;

  sdac_frame_rx i_sdac_frame_rx (
    .clk(clk), .rst(rst), .sync_n_i(sync_n), .sclk_i(sclk), .din_i(din),
    .code_o(code), .mode_o(mode), .offset_o(offset), .update_o(upd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (upd) begin
        chk(!upd_prev, "R8 strobe width", 32'(upd_prev), 32'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected update", 32'(code), 32'd0);
        end else begin
          logic [23:0] w;
          w = exp_q.pop_front();
          chk(code == w[15:0], "R3 code", 32'(code), 32'(w[15:0]));
          chk(mode == w[23:16], "R3 mode", 32'(mode), 32'(w[23:16]));
          chk(offset == {~w[15], w[14:0]}, "R7 offset", 32'(offset),
              32'({~w[15], w[14:0]}));
        end
      end
      upd_prev = upd;
    end
  end

  task automatic send(input logic [23:0] w, input int nbits, input int extra,
                      input bit coincide);
    if (nbits == 24) exp_q.push_back(w);
    sclk = 1'b1;
    wclk(4);
    if (!coincide) begin
      sync_n = 1'b0;
      wclk(4);
    end
    for (int i = 0; i < nbits; i++) begin
      din = w[23-i];
      wclk(4);
      sclk = 1'b0;
      if (coincide && i == 0) sync_n = 1'b0;
      wclk(4);
      sclk = 1'b1;
    end
    for (int j = 0; j < extra; j++) begin
      din = ~din;
      wclk(4);
      sclk = 1'b0;
      wclk(4);
      sclk = 1'b1;
    end
    wclk(4);
    sync_n = 1'b1;
    wclk(8);
  endtask

  initial begin
    wclk(4);
    rst = 1'b0;
    wclk(3);
    // R1 reset state
    chk(code == 16'h0000, "R1 code", 32'(code), 32'h0);
    chk(mode == 8'h00, "R1 mode", 32'(mode), 32'h0);
    chk(offset == 16'h8000, "R1 offset", 32'(offset), 32'h8000);
    chk(upd == 1'b0, "R1 strobe", 32'(upd), 32'h0);

    send(24'h12_8000, 24, 0, 1'b0);   // R4 R7 negative full scale
    send(24'h34_7FFF, 24, 0, 1'b0);   // R7 positive full scale
    send(24'hA5_0000, 24, 0, 1'b0);   // R7 mid-scale
    send(24'hFF_FFFF, 10, 0, 1'b0);   // R6 abort
    chk(code == 16'h0000, "R6 code kept", 32'(code), 32'h0);
    chk(mode == 8'hA5, "R6 mode kept", 32'(mode), 32'hA5);
    send(24'h5A_1234, 24, 6, 1'b0);   // R5 extra edges ignored
    chk(code == 16'h1234, "R5 code", 32'(code), 32'h1234);
    chk(mode == 8'h5A, "R5 mode", 32'(mode), 32'h5A);
    send(24'hC3_FEDC, 24, 0, 1'b1);   // R9 coincident edges
    chk(code == 16'hFEDC, "R9 code", 32'(code), 32'hFEDC);
    send(24'h00_0000, 23, 0, 1'b0);   // R6 abort one bit short
    chk(code == 16'hFEDC, "R6 code kept", 32'(code), 32'hFEDC);
    chk(offset == 16'h7EDC, "R6 offset kept", 32'(offset), 32'h7EDC);
    send(24'h01_ABCD, 24, 0, 1'b0);   // R2 fresh frame after abort
    chk(code == 16'hABCD, "R2 code", 32'(code), 32'hABCD);
    chk(mode == 8'h01, "R2 mode", 32'(mode), 32'h01);
    wclk(10);
    chk(exp_q.size() == 0, "R4 R9 frames executed", 32'(exp_q.size()), 32'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule